// File: doc/BRIEF.md
# Indexed Two-Bit Branch Predictor

This block is a small direct-mapped table of two-bit state machines that predicts whether a conditional branch will be taken. A lookup port takes an instruction address and returns a taken or not-taken guess in the same cycle, with no register on the path. An update port takes the address of a branch that has been resolved, together with its real outcome, and moves the state machine of the matching entry one step.

The state machines do not count up and down symmetrically. When a branch in the weak not-taken state is taken, its entry goes straight to strong taken. When a branch in any state below strong taken is not taken, its entry drops back to strong not-taken. The block also keeps a saturating count of mispredictions. A misprediction is an update whose outcome differs from the guess that entry held just before the update.

Top module: `bp_predictor`

## Requirements
- R1: While rst_ni is low, and right after it rises, every entry is in state 0 (predicts not taken) and miss_count_o is 0.
- R2: The entry is chosen by address bits [3:2] (for the default 4 entries). Bits [1:0] and all bits above bit 3 have no effect on which entry is read or updated.
- R3: lookup_taken_o is 1 for states 2 and 3 and 0 for states 0 and 1. It is combinational from lookup_pc_i and the table contents.
- R4: From state 0, a taken update moves the entry to state 1 and a not-taken update leaves it in state 0.
- R5: From state 1 or state 2, a taken update moves the entry to state 3 and a not-taken update moves it to state 0.
- R6: From state 3, a taken update leaves it in state 3 and a not-taken update moves it to state 2.
- R7: On each rising edge with upd_valid_i high, miss_count_o grows by one when upd_taken_i differs from the prediction the addressed entry held before that edge. Otherwise it holds.
- R8: A lookup of the entry that is being updated in the same cycle returns the prediction from before the update. The new prediction appears after the clock edge.
- R9: miss_count_o saturates at its all-ones value.
- R10: While upd_valid_i is low, no entry and no count changes, whatever upd_pc_i and upd_taken_i hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | PC_W | Address of the branch to predict |
| lookup_taken_o | output | 1 | Prediction: 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Real outcome of the resolved branch |
| miss_count_o | output | CNT_W | Saturating misprediction count |

## Verification
The hardest case to reach is an entry in state 2. It can only be entered from state 3 through a single not-taken outcome, and it has to be told apart from state 3, because both predict taken. The stimulus walks one entry through 0, 1, 3, 2, 3, 2 and then 0. It uses the miss count and the prediction after each step to show which state was passed through. Reaching saturation needs long runs of mispredictions, so the bench builds the block with a narrow counter and repeats a taken, taken, not-taken, not-taken pattern, which mispredicts on every update.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    ST_SNT = 2'd0,
    ST_WNT = 2'd1,
    ST_WT  = 2'd2,
    ST_ST  = 2'd3
  } bp_state_e;

  function automatic bp_state_e bp_next(input bp_state_e cur, input logic taken);
    unique case (cur)
      ST_SNT:        return taken ? ST_WNT : ST_SNT;
      ST_WNT, ST_WT: return taken ? ST_ST  : ST_SNT;
      default:       return taken ? ST_ST  : ST_WT;
    endcase
  endfunction

  function automatic logic bp_pred(input bp_state_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic unused_bits;
  assign unused_bits = ^{pc_i[1:0], pc_i[PC_W-1:IDX_W+2]};
  assign idx_o = pc_i[IDX_W+1:2];
endmodule

// File: rtl/bp_entry.sv
module bp_entry
  import bp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      upd_en_i,
  input  logic      taken_i,
  output bp_state_e state_o
);
  bp_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_SNT;
    else if (upd_en_i) state_q <= bp_next(state_q, taken_i);
  end

  assign state_o = state_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(state_q));
  p_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !taken_i && state_q != ST_ST) |=> state_q == ST_SNT);
  p_top_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && taken_i && state_q == ST_ST) |=> state_q == ST_ST);
endmodule

// File: rtl/bp_miss_ctr.sv
module bp_miss_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  p_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax) |=> cnt_q == CntMax);
  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lookup_pc_i,
  output logic             lookup_taken_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  output logic [CNT_W-1:0] miss_count_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] lkp_idx, upd_idx;
  bp_state_e        state_q [ENTRIES];
  logic             upd_pred, miss;

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lkp_idx (.pc_i(lookup_pc_i), .idx_o(lkp_idx));
  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_idx (.pc_i(upd_pc_i),    .idx_o(upd_idx));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    bp_entry u_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .upd_en_i(upd_valid_i && (upd_idx == IDX_W'(g))),
      .taken_i (upd_taken_i),
      .state_o (state_q[g])
    );
  end

  assign lookup_taken_o = bp_pred(state_q[lkp_idx]);
  assign upd_pred       = bp_pred(state_q[upd_idx]);
  // compare actual outcome with the guess held before this edge
  assign miss           = upd_valid_i && (upd_taken_i != upd_pred);

  bp_miss_ctr #(.CNT_W(CNT_W)) u_miss_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (miss),
    .count_o(miss_count_o)
  );

  p_mono_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_count_o >= $past(miss_count_o));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(miss_count_o));
  p_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i == upd_pred) |=> $stable(miss_count_o));
endmodule

// File: tb/bp_predictor_tb.sv
module bp_predictor_tb;
  localparam int CW = 4;
  logic          clk = 0;
  logic          rst_ni = 0;
  logic [31:0]   lookup_pc = '0;
  logic          lookup_taken;
  logic          upd_valid = 0;
  logic [31:0]   upd_pc = '0;
  logic          upd_taken = 0;
  logic [CW-1:0] miss_count;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bp_predictor #(.PC_W(32), .ENTRIES(4), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_pc_i(lookup_pc),
    .lookup_taken_o(lookup_taken), .upd_valid_i(upd_valid),
    .upd_pc_i(upd_pc), .upd_taken_i(upd_taken), .miss_count_o(miss_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // {valid, pc[7:0], taken, exp_pred_after, exp_cnt[3:0]}
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 8'h00, 1'b1, 1'b0, 4'd1},  // 0->1 (R4)
    {1'b1, 8'h00, 1'b1, 1'b1, 4'd2},  // 1->3 (R5)
    {1'b1, 8'h00, 1'b0, 1'b1, 4'd3},  // 3->2 (R6)
    {1'b1, 8'h00, 1'b1, 1'b1, 4'd3},  // 2->3 (R5)
    {1'b1, 8'h00, 1'b0, 1'b1, 4'd4},  // 3->2
    {1'b1, 8'h00, 1'b0, 1'b0, 4'd5},  // 2->0 (R5)
    {1'b1, 8'h00, 1'b0, 1'b0, 4'd5},  // 0->0 (R4)
    {1'b1, 8'h17, 1'b1, 1'b0, 4'd6},  // alias of idx1 (R2)
    {1'b1, 8'h04, 1'b0, 1'b0, 4'd6},  // 1->0
    {1'b1, 8'h04, 1'b1, 1'b0, 4'd7},
    {1'b1, 8'h04, 1'b1, 1'b1, 4'd8},
    {1'b1, 8'h04, 1'b1, 1'b1, 4'd8},  // 3->3 (R6)
    {1'b0, 8'h04, 1'b0, 1'b1, 4'd8},  // idle (R10)
    {1'b1, 8'h08, 1'b0, 1'b0, 4'd8},
    {1'b1, 8'h0C, 1'b1, 1'b0, 4'd9}
  };

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #35;
    for (int k = 0; k < 4; k++) begin
      lookup_pc = 32'(k * 4); #1;
      chk("R1 pred in reset", {31'b0, lookup_taken}, 0);
    end
    chk("R1 count in reset", {28'b0, miss_count}, 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk("R1 count after reset", {28'b0, miss_count}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_valid = VEC[i][14];
      upd_pc    = {24'hA5A5A5, VEC[i][13:6]};
      upd_taken = VEC[i][5];
      lookup_pc = {24'h3C3C3C, VEC[i][13:6] ^ 8'hF0}; // other high bits, same idx (R2)
      @(posedge clk); #5;
      upd_valid = 0;
      chk($sformatf("R3/R4/R5/R6 pred after vec %0d", i), {31'b0, lookup_taken}, {31'b0, VEC[i][4]});
      chk($sformatf("R7 count after vec %0d", i), {28'b0, miss_count}, {28'b0, VEC[i][3:0]});
    end

    // other entries untouched by traffic elsewhere (R2)
    lookup_pc = 32'h0000_0001; #1;
    chk("R2 idx0 state0", {31'b0, lookup_taken}, 0);
    lookup_pc = 32'hFFFF_FF06; #1;
    chk("R2 idx1 state3", {31'b0, lookup_taken}, 1);

    // same-cycle lookup returns old prediction (R8): idx3 state1, taken -> 3
    @(negedge clk);
    upd_valid = 1; upd_pc = 32'h0C; upd_taken = 1; lookup_pc = 32'h0C; #1;
    chk("R8 pre-update pred", {31'b0, lookup_taken}, 0);
    @(posedge clk); #5; upd_valid = 0;
    chk("R8 post-update pred", {31'b0, lookup_taken}, 1);
    chk("R7 count after R8 step", {28'b0, miss_count}, 10);

    // saturation (R9): idx2 from state0, T,T,N,N misses every time
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      upd_valid = 1; upd_pc = 32'h08; upd_taken = (j % 4) < 2;
      @(posedge clk); #5; upd_valid = 0;
      if (j == 4) chk("R7 count mid run", {28'b0, miss_count}, 15);
    end
    chk("R9 saturated count", {28'b0, miss_count}, 15);
    lookup_pc = 32'h08; #1;
    chk("R4 idx2 back to state0", {31'b0, lookup_taken}, 0);

    // idle with misleading inputs (R10)
    @(negedge clk);
    upd_valid = 0; upd_pc = 32'h04; upd_taken = 0; lookup_pc = 32'h04;
    repeat (3) @(posedge clk); #5;
    chk("R10 idx1 unchanged", {31'b0, lookup_taken}, 1);

    // asynchronous reset mid-run (R1)
    @(negedge clk); #3; rst_ni = 0; #1;
    chk("R1 async clear count", {28'b0, miss_count}, 0);
    chk("R1 async clear entry", {31'b0, lookup_taken}, 0);
    @(negedge clk); rst_ni = 1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule